// File: doc/BRIEF.md
# DDR2 Rank Command Timing Monitor

This block sits beside a DRAM controller and watches every command the controller sends to one eight-bank DDR2 rank. Each clock it takes one decoded command, a bank number and an auto-precharge flag. One cycle later it reports whether that command broke an inter-command timing rule. A one-hot code names every rule that was broken, and several code bits may be set at once. It generates no commands, decodes no addresses and carries no data. It is a passive observer for simulation monitors, emulation builds or on-chip debug.

All limits are given in picoseconds as parameters. At elaboration they are turned into clock counts by rounding up against a clock-period parameter. The write-recovery, read-to-precharge and write-to-read counts are never allowed below two clocks. Each bank keeps its own countdown timers. Bus-wide timers cover activate spacing, column spacing, mode-register settling and write-to-read turnaround. A four-deep record of recent activates enforces the rolling activate window.

The command stream is observed, never stalled, so the block has no valid/ready handshake and applies no back-pressure. Every command is applied to the tracked bank state, even one that is flagged, so the block keeps following what the DRAM actually receives.

Top module: `dram_cmd_timing_chk`

## Requirements
- R1: Command encoding on `cmd_i`: 0 idle, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 mode load, and 7 behaves as idle. The outputs are registered and report the command seen at the previous edge. `viol_o` is high exactly when `viol_code_o` is non-zero. An idle command never flags, and reset clears both outputs.
- R2: Code bit 0 is set when an activate comes within the activate-to-activate spacing (7.5 ns, at least 2 clocks) of the previous activate to any bank.
- R3: Code bit 1 is set when an activate comes fewer than ceil(37.5 ns / period) clocks after the fourth-most-recent activate, whichever banks those activates used.
- R4: Code bit 2 is set when a read or write comes within the activate-to-column delay (15 ns by default) of the last activate to that bank.
- R5: Code bit 3 is set when an activate comes within the activate-to-activate same-bank period (55 ns by default) of the last activate to that bank.
- R6: Code bit 4 is set when an activate comes before the bank's precharge has completed. A single-bank precharge needs ceil(tRP) clocks. A precharge-all needs one clock more, for every bank.
- R7: Code bit 5 is set when a precharge or precharge-all reaches an open bank before the activate-to-precharge minimum (40 ns) has passed. A read or write with auto-precharge never sets this bit.
- R8: Code bit 6 is set when a precharge reaches an open bank fewer than BL/2 + max(2, ceil(tRTP)) - 2 clocks after a read to it.
- R9: Code bit 7 is set when a precharge reaches an open bank fewer than (CL-1) + BL/2 + max(2, ceil(tWR)) clocks after a write to it.
- R10: Code bit 8 is set when a read comes fewer than (CL-1) + BL/2 + max(2, ceil(tWTR)) clocks after any write.
- R11: Code bit 9 is set when two column commands come less than 2 clocks apart. Code bit 10 is set when any non-idle command follows a mode load by less than 2 clocks.
- R12: Code bit 11 is set when an activate targets an already open bank, or a read or write targets a closed bank.
- R13: An auto-precharge closes the bank. The internal precharge starts at the later of the activate-to-precharge minimum and the read-to-precharge or write-to-precharge delay. The next activate to that bank is allowed ceil(tRP) clocks after that point. For a write, this is the write-recovery clocks plus the rounded-up precharge clocks past the burst end. Earlier activates set bit 4.
- R14: When one command breaks several rules, all matching code bits are set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command, encoding in R1 |
| bank_i | input | 3 | Target bank (ignored for precharge-all and mode load) |
| ap_i | input | 1 | Auto-precharge flag for reads and writes |
| viol_o | output | 1 | One-cycle pulse: the previous command broke a rule |
| viol_code_o | output | 12 | One-hot per rule, bit positions in R2 to R12 |

## Verification
The hardest cases to reach are the exact clock boundaries. Two examples are the fifth activate inside the rolling window, and an activate right after an auto-precharged write whose recovery is set by the later of tRAS and write recovery. Random traffic rarely lines these up, so directed sequences place commands exactly one clock before and exactly on each boundary. Seeded random traffic over all eight banks then mixes activates, column commands, precharges and mode loads, which gives overlapping timers and multi-bit codes. A bench reference model keeps absolute-cycle deadlines and predicts every output.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_LMR  = 3'd6,
    CMD_RSV  = 3'd7
  } dct_cmd_e;

  localparam int RULE_RRD   = 0;
  localparam int RULE_FAW   = 1;
  localparam int RULE_RCD   = 2;
  localparam int RULE_RC    = 3;
  localparam int RULE_RP    = 4;
  localparam int RULE_RAS   = 5;
  localparam int RULE_RTP   = 6;
  localparam int RULE_WR    = 7;
  localparam int RULE_WTR   = 8;
  localparam int RULE_CCD   = 9;
  localparam int RULE_MRD   = 10;
  localparam int RULE_STATE = 11;
  localparam int NRULE      = 12;

  // picoseconds to clocks, rounded up, never below lo
  function automatic int clk_of(input int ps, input int tck, input int lo);
    int c;
    c = (ps + tck - 1) / tck;
    return (c < lo) ? lo : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dct_bank_timer.sv
module dct_bank_timer #(
  parameter int TW     = 8,
  parameter int NRC    = 15,
  parameter int NRCD   = 4,
  parameter int NRAS   = 11,
  parameter int NRP    = 4,
  parameter int NRPA   = 5,
  parameter int RD2PRE = 2,
  parameter int WR2PRE = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic pre_i,
  input  logic prea_i,
  input  logic ap_i,
  output logic open_o,
  output logic rc_busy_o,
  output logic rp_busy_o,
  output logic rcd_busy_o,
  output logic ras_busy_o,
  output logic rtp_busy_o,
  output logic wr_busy_o
);
  // each timer holds the clocks still to wait before its command is legal
  logic [TW-1:0] rc_t, rp_t, rcd_t, ras_t, rtp_t, wr_t;
  logic          open_q;

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] x);
    return (x == '0) ? x : x - TW'(1);
  endfunction

  function automatic logic [TW-1:0] tmax(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rc_t   <= '0;
      rp_t   <= '0;
      rcd_t  <= '0;
      ras_t  <= '0;
      rtp_t  <= '0;
      wr_t   <= '0;
    end else begin
      rc_t  <= dec(rc_t);
      rp_t  <= dec(rp_t);
      rcd_t <= dec(rcd_t);
      ras_t <= dec(ras_t);
      rtp_t <= dec(rtp_t);
      wr_t  <= dec(wr_t);
      if (act_i) begin
        open_q <= 1'b1;
        rc_t   <= TW'(NRC - 1);
        rcd_t  <= TW'(NRCD - 1);
        ras_t  <= TW'(NRAS - 1);
      end
      if (rd_i) begin
        rtp_t <= tmax(dec(rtp_t), TW'(RD2PRE - 1));
        if (ap_i) begin
          open_q <= 1'b0;
          rp_t   <= tmax(dec(rp_t), tmax(TW'(RD2PRE), ras_t) + TW'(NRP - 1));
        end
      end
      if (wr_i) begin
        wr_t <= tmax(dec(wr_t), TW'(WR2PRE - 1));
        if (ap_i) begin
          open_q <= 1'b0;
          rp_t   <= tmax(dec(rp_t), tmax(TW'(WR2PRE), ras_t) + TW'(NRP - 1));
        end
      end
      if (pre_i) begin
        open_q <= 1'b0;
        rp_t   <= tmax(dec(rp_t), TW'(NRP - 1));
      end
      if (prea_i) begin
        open_q <= 1'b0;
        rp_t   <= tmax(dec(rp_t), TW'(NRPA - 1));
      end
    end
  end

  assign open_o     = open_q;
  assign rc_busy_o  = (rc_t  != '0);
  assign rp_busy_o  = (rp_t  != '0);
  assign rcd_busy_o = (rcd_t != '0);
  assign ras_busy_o = (ras_t != '0);
  assign rtp_busy_o = (rtp_t != '0);
  assign wr_busy_o  = (wr_t  != '0);
endmodule

// File: rtl/dct_act_window.sv
module dct_act_window #(
  parameter int TW    = 8,
  parameter int DEPTH = 4,
  parameter int NFAW  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic busy_o
);
  // remaining window time of the most recent DEPTH activates, newest first
  logic [TW-1:0] win [DEPTH];

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] x);
    return (x == '0) ? x : x - TW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     win[0] <= '0;
        else if (act_i) win[0] <= TW'(NFAW - 1);
        else            win[0] <= dec(win[0]);
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     win[i] <= '0;
        else if (act_i) win[i] <= dec(win[i-1]);
        else            win[i] <= dec(win[i]);
      end
    end
  end

  assign busy_o = (win[DEPTH-1] != '0);
endmodule

// File: rtl/dct_bus_timer.sv
module dct_bus_timer #(
  parameter int TW    = 8,
  parameter int NRRD  = 2,
  parameter int NCCD  = 2,
  parameter int NMRD  = 2,
  parameter int WR2RD = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic col_i,
  input  logic wr_i,
  input  logic lmr_i,
  output logic rrd_busy_o,
  output logic ccd_busy_o,
  output logic mrd_busy_o,
  output logic wtr_busy_o
);
  logic [TW-1:0] rrd_t, ccd_t, mrd_t, wtr_t;

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] x);
    return (x == '0) ? x : x - TW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_t <= '0;
      ccd_t <= '0;
      mrd_t <= '0;
      wtr_t <= '0;
    end else begin
      rrd_t <= act_i ? TW'(NRRD - 1) : dec(rrd_t);
      ccd_t <= col_i ? TW'(NCCD - 1) : dec(ccd_t);
      mrd_t <= lmr_i ? TW'(NMRD - 1) : dec(mrd_t);
      if (wr_i && (dec(wtr_t) < TW'(WR2RD - 1))) wtr_t <= TW'(WR2RD - 1);
      else                                       wtr_t <= dec(wtr_t);
    end
  end

  assign rrd_busy_o = (rrd_t != '0);
  assign ccd_busy_o = (ccd_t != '0);
  assign mrd_busy_o = (mrd_t != '0);
  assign wtr_busy_o = (wtr_t != '0);
endmodule

// File: rtl/dram_cmd_timing_chk.sv
module dram_cmd_timing_chk
  import dct_pkg::*;
#(
  parameter int NBANK    = 8,
  parameter int TCK_PS   = 3750,
  parameter int T_RRD_PS = 7500,
  parameter int T_FAW_PS = 37500,
  parameter int T_RCD_PS = 15000,
  parameter int T_RC_PS  = 55000,
  parameter int T_RAS_PS = 40000,
  parameter int T_RP_PS  = 15000,
  parameter int T_WR_PS  = 15000,
  parameter int T_RTP_PS = 7500,
  parameter int T_WTR_PS = 7500,
  parameter int CAS_LAT  = 4,
  parameter int BURST    = 4,
  parameter int ACT_WIN  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  cmd_i,
  input  logic [$clog2(NBANK)-1:0]    bank_i,
  input  logic                        ap_i,
  output logic                        viol_o,
  output logic [dct_pkg::NRULE-1:0]   viol_code_o
);
  localparam int BA_W   = $clog2(NBANK);
  localparam int NRRD   = clk_of(T_RRD_PS, TCK_PS, 2);
  localparam int NFAW   = clk_of(T_FAW_PS, TCK_PS, 1);
  localparam int NRCD   = clk_of(T_RCD_PS, TCK_PS, 1);
  localparam int NRC    = clk_of(T_RC_PS,  TCK_PS, 1);
  localparam int NRAS   = clk_of(T_RAS_PS, TCK_PS, 1);
  localparam int NRP    = clk_of(T_RP_PS,  TCK_PS, 1);
  localparam int NRPA   = NRP + 1;
  localparam int NWR    = clk_of(T_WR_PS,  TCK_PS, 2);
  localparam int NRTP   = clk_of(T_RTP_PS, TCK_PS, 2);
  localparam int NWTR   = clk_of(T_WTR_PS, TCK_PS, 2);
  localparam int HALFBL = BURST / 2;
  localparam int WLAT   = CAS_LAT - 1;
  localparam int RD2PRE = HALFBL + NRTP - 2;
  localparam int WR2PRE = WLAT + HALFBL + NWR;
  localparam int WR2RD  = WLAT + HALFBL + NWTR;
  localparam int NCCD   = 2;
  localparam int NMRD   = 2;
  localparam int MAXC   = imax(imax(NRC, NFAW), imax(WR2PRE, NRAS) + NRPA + WR2RD);
  localparam int TW     = $clog2(MAXC + 2);

  dct_cmd_e cmd;
  assign cmd = dct_cmd_e'(cmd_i);

  logic is_act, is_rd, is_wr, is_pre, is_prea, is_lmr, is_col, is_live;
  assign is_act  = (cmd == CMD_ACT);
  assign is_rd   = (cmd == CMD_RD);
  assign is_wr   = (cmd == CMD_WR);
  assign is_pre  = (cmd == CMD_PRE);
  assign is_prea = (cmd == CMD_PREA);
  assign is_lmr  = (cmd == CMD_LMR);
  assign is_col  = is_rd | is_wr;
  assign is_live = (cmd != CMD_NOP) && (cmd != CMD_RSV);

  logic [NBANK-1:0] open_v, rc_v, rp_v, rcd_v, ras_v, rtp_v, wr_v;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BA_W'(b));
    dct_bank_timer #(
      .TW(TW), .NRC(NRC), .NRCD(NRCD), .NRAS(NRAS), .NRP(NRP),
      .NRPA(NRPA), .RD2PRE(RD2PRE), .WR2PRE(WR2PRE)
    ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (is_act & hit),
      .rd_i      (is_rd & hit),
      .wr_i      (is_wr & hit),
      .pre_i     (is_pre & hit),
      .prea_i    (is_prea),
      .ap_i      (ap_i),
      .open_o    (open_v[b]),
      .rc_busy_o (rc_v[b]),
      .rp_busy_o (rp_v[b]),
      .rcd_busy_o(rcd_v[b]),
      .ras_busy_o(ras_v[b]),
      .rtp_busy_o(rtp_v[b]),
      .wr_busy_o (wr_v[b])
    );
  end

  logic faw_busy, rrd_busy, ccd_busy, mrd_busy, wtr_busy;

  dct_act_window #(.TW(TW), .DEPTH(ACT_WIN), .NFAW(NFAW)) i_window (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (is_act),
    .busy_o(faw_busy)
  );

  dct_bus_timer #(.TW(TW), .NRRD(NRRD), .NCCD(NCCD), .NMRD(NMRD), .WR2RD(WR2RD)) i_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (is_act),
    .col_i     (is_col),
    .wr_i      (is_wr),
    .lmr_i     (is_lmr),
    .rrd_busy_o(rrd_busy),
    .ccd_busy_o(ccd_busy),
    .mrd_busy_o(mrd_busy),
    .wtr_busy_o(wtr_busy)
  );

  logic [NRULE-1:0] code_n, code_q;
  logic             viol_q;

  always_comb begin
    code_n = '0;
    code_n[RULE_MRD] = is_live & mrd_busy;
    unique case (cmd)
      CMD_ACT: begin
        code_n[RULE_STATE] = open_v[bank_i];
        code_n[RULE_RC]    = rc_v[bank_i];
        code_n[RULE_RP]    = rp_v[bank_i];
        code_n[RULE_RRD]   = rrd_busy;
        code_n[RULE_FAW]   = faw_busy;
      end
      CMD_RD, CMD_WR: begin
        code_n[RULE_STATE] = ~open_v[bank_i];
        code_n[RULE_RCD]   = rcd_v[bank_i];
        code_n[RULE_CCD]   = ccd_busy;
        code_n[RULE_WTR]   = is_rd & wtr_busy;
      end
      CMD_PRE: begin
        code_n[RULE_RAS] = open_v[bank_i] & ras_v[bank_i];
        code_n[RULE_RTP] = open_v[bank_i] & rtp_v[bank_i];
        code_n[RULE_WR]  = open_v[bank_i] & wr_v[bank_i];
      end
      CMD_PREA: begin
        code_n[RULE_RAS] = |(open_v & ras_v);
        code_n[RULE_RTP] = |(open_v & rtp_v);
        code_n[RULE_WR]  = |(open_v & wr_v);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      viol_q <= 1'b0;
    end else begin
      code_q <= code_n;
      viol_q <= |code_n;
    end
  end

  assign viol_o      = viol_q;
  assign viol_code_o = code_q;
endmodule

// File: rtl/dram_cmd_timing_chk_sva.sv
module dram_cmd_timing_chk_sva
  import dct_pkg::*;
#(
  parameter int BA_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd_i,
  input logic [BA_W-1:0]   bank_i,
  input logic              viol_o,
  input logic [NRULE-1:0]  viol_code_o
);
  logic            prev_act, prev_col, prev_lmr;
  logic [BA_W-1:0] prev_bank;
  logic            now_col, now_live;

  assign now_col  = (cmd_i == 3'd2) || (cmd_i == 3'd3);
  assign now_live = (cmd_i != 3'd0) && (cmd_i != 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act  <= 1'b0;
      prev_col  <= 1'b0;
      prev_lmr  <= 1'b0;
      prev_bank <= '0;
    end else begin
      prev_act  <= (cmd_i == 3'd1);
      prev_col  <= now_col;
      prev_lmr  <= (cmd_i == 3'd6);
      prev_bank <= bank_i;
    end
  end

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd0) |=> !viol_o); // R1

  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == 3'd1) && prev_act) |=> viol_code_o[RULE_RRD]); // R2

  AST_AP_NO_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    now_col |=> !viol_code_o[RULE_RAS]); // R7

  AST_COL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (now_col && prev_col) |=> viol_code_o[RULE_CCD]); // R11

  AST_MODE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (now_live && prev_lmr) |=> viol_code_o[RULE_MRD]); // R11

  AST_REOPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == 3'd1) && prev_act && (bank_i == prev_bank)) |=> viol_code_o[RULE_STATE]); // R12
endmodule

bind dram_cmd_timing_chk dram_cmd_timing_chk_sva #(.BA_W(BA_W)) i_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_i      (cmd_i),
  .bank_i     (bank_i),
  .viol_o     (viol_o),
  .viol_code_o(viol_code_o)
);

// File: tb/test_dram_cmd_timing_chk.sv
module test_dram_cmd_timing_chk;
  localparam int NB = 8;
  // clock counts derived independently from the requirement limits (3.75 ns period)
  function automatic int cdiv(input int ps, input int lo);
    int c;
    c = (ps + 3749) / 3750;
    return (c < lo) ? lo : c;
  endfunction
  localparam int C_RRD = cdiv(7500, 2);
  localparam int C_FAW = cdiv(37500, 1);
  localparam int C_RCD = cdiv(15000, 1);
  localparam int C_RC  = cdiv(55000, 1);
  localparam int C_RAS = cdiv(40000, 1);
  localparam int C_RP  = cdiv(15000, 1);
  localparam int C_RD2PRE = 2 + cdiv(7500, 2) - 2;
  localparam int C_WR2PRE = 3 + 2 + cdiv(15000, 2);
  localparam int C_WR2RD  = 3 + 2 + cdiv(7500, 2);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [2:0]  bank_i = 3'd0;
  logic        ap_i = 1'b0;
  logic        viol_o;
  logic [11:0] viol_code_o;

  int checks = 0;
  int fails = 0;
  int n = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  dram_cmd_timing_chk i_dram_cmd_timing_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
    .ap_i(ap_i), .viol_o(viol_o), .viol_code_o(viol_code_o)
  );

  // reference model: absolute cycle at which each command becomes legal
  int m_open [NB];
  int m_rc [NB], m_rp [NB], m_rcd [NB], m_ras [NB], m_rtp [NB], m_wr [NB];
  int m_rrd, m_ccd, m_mrd, m_wtr;
  int m_acts [4];

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic void model_reset();
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_rc[b] = -1000; m_rp[b] = -1000; m_rcd[b] = -1000;
      m_ras[b] = -1000; m_rtp[b] = -1000; m_wr[b] = -1000;
    end
    m_rrd = -1000; m_ccd = -1000; m_mrd = -1000; m_wtr = -1000;
    for (int k = 0; k < 4; k++) m_acts[k] = -1000;
  endfunction

  function automatic logic [11:0] model_eval(input int c, input int b);
    logic [11:0] e;
    e = '0;
    if (c >= 1 && c <= 6 && n < m_mrd) e[10] = 1;
    case (c)
      1: begin
        e[11] = (m_open[b] != 0); e[3] = (n < m_rc[b]); e[4] = (n < m_rp[b]);
        e[0] = (n < m_rrd); e[1] = (n < m_acts[3] + C_FAW);
      end
      2, 3: begin
        e[11] = (m_open[b] == 0); e[2] = (n < m_rcd[b]); e[9] = (n < m_ccd);
        if (c == 2) e[8] = (n < m_wtr);
      end
      4: if (m_open[b] != 0) begin
        e[5] = (n < m_ras[b]); e[6] = (n < m_rtp[b]); e[7] = (n < m_wr[b]);
      end
      5: for (int k = 0; k < NB; k++) if (m_open[k] != 0) begin
        if (n < m_ras[k]) e[5] = 1;
        if (n < m_rtp[k]) e[6] = 1;
        if (n < m_wr[k])  e[7] = 1;
      end
      default: ;
    endcase
    return e;
  endfunction

  function automatic void model_update(input int c, input int b, input bit ap);
    case (c)
      1: begin
        m_open[b] = 1; m_rc[b] = n + C_RC; m_rcd[b] = n + C_RCD; m_ras[b] = n + C_RAS;
        m_rrd = n + C_RRD;
        for (int k = 3; k > 0; k--) m_acts[k] = m_acts[k-1];
        m_acts[0] = n;
      end
      2: begin
        m_rtp[b] = mx(m_rtp[b], n + C_RD2PRE); m_ccd = n + 2;
        if (ap) begin m_open[b] = 0; m_rp[b] = mx(m_rp[b], mx(n + C_RD2PRE, m_ras[b]) + C_RP); end
      end
      3: begin
        m_wr[b] = mx(m_wr[b], n + C_WR2PRE); m_ccd = n + 2; m_wtr = mx(m_wtr, n + C_WR2RD);
        if (ap) begin m_open[b] = 0; m_rp[b] = mx(m_rp[b], mx(n + C_WR2PRE, m_ras[b]) + C_RP); end
      end
      4: begin m_open[b] = 0; m_rp[b] = mx(m_rp[b], n + C_RP); end
      5: for (int k = 0; k < NB; k++) begin m_open[k] = 0; m_rp[k] = mx(m_rp[k], n + C_RP + 1); end
      6: m_mrd = n + 2;
      default: ;
    endcase
  endfunction

  function automatic string rule_req(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6 R13";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      8: return "R10";
      9, 10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic step(input int c, input int b, input bit ap);
    logic [11:0] e;
    string req;
    e = model_eval(c, b);
    model_update(c, b, ap);
    cmd_i = 3'(c); bank_i = 3'(b); ap_i = ap;
    @(negedge clk);
    checks++;
    if (viol_o !== (e != 0) || viol_code_o !== e) begin
      req = "R1";
      for (int i = 11; i >= 0; i--) if (viol_code_o[i] !== e[i]) req = rule_req(i);
      if ($countones(e) > 1) req = {req, " R14"};
      fails++;
      $display("FAIL %s cmd %0d bank %0d step %0d: viol=%0b code=%03h expected viol=%0b code=%03h",
               req, c, b, n, viol_o, viol_code_o, (e != 0), e);
    end
    n++;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if (viol_o !== 1'b0 || viol_code_o !== '0) begin
      fails++;
      $display("FAIL R1 reset: viol=%0b code=%03h expected viol=0 code=000", viol_o, viol_code_o);
    end
    rst_n = 1'b1;
    idle(2);

    // R3 R2: five activates two clocks apart, fifth inside the window
    for (int b = 0; b < 6; b++) begin step(1, b, 0); step(0, 0, 0); end
    step(1, 6, 0); // R2 back-to-back activates
    step(1, 7, 0);
    idle(14); step(5, 0, 0); idle(8);

    // R13 R7: write with auto-precharge, activate one clock early then on time
    step(1, 1, 0); idle(3); step(3, 1, 1); idle(11); step(1, 1, 0); // early by one
    idle(16); step(5, 0, 0); idle(8);
    step(1, 2, 0); idle(3); step(3, 2, 1); idle(12); step(1, 2, 0); // exactly on time
    idle(16); step(5, 0, 0); idle(8);
    // R13: read with auto-precharge before tRAS, internal precharge waits for it
    step(1, 3, 0); idle(3); step(2, 3, 1); idle(9); step(1, 3, 0); idle(1); step(1, 4, 0);
    idle(16); step(5, 0, 0); idle(8);

    // R6: precharge-all needs one clock more than a single-bank precharge
    step(1, 0, 0); idle(11); step(5, 0, 0); idle(3); step(1, 0, 0); step(0, 0, 0); step(1, 1, 0);
    idle(16); step(5, 0, 0); idle(8);

    // R10 R9 R8 R7 R4: column and precharge spacing on one bank
    step(1, 0, 0); idle(2); step(3, 0, 0); idle(1); step(2, 0, 0); idle(5); step(4, 0, 0);
    idle(16); step(1, 5, 0); idle(4); step(2, 5, 0); step(4, 5, 0); idle(10); step(4, 5, 0);
    idle(16); step(5, 0, 0); idle(8);

    // R14 R12 R11: mode load followed at once by a read to a closed bank
    step(6, 0, 0); step(2, 4, 0); idle(2); step(6, 0, 0); idle(1); step(1, 4, 0); step(1, 4, 0);
    idle(16); step(5, 0, 0); idle(8);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r, c;
      r = $urandom % 16;
      if (r < 6) c = 0;
      else if (r < 9) c = 1;
      else if (r < 11) c = 2;
      else if (r < 13) c = 3;
      else if (r == 13) c = 4;
      else if (r == 14) c = (($urandom % 4) == 0) ? 5 : 0;
      else c = (($urandom % 6) == 0) ? 6 : 0;
      step(c, $urandom % NB, 1'($urandom % 2));
    end
    finish_run();
  end
endmodule